// File: doc/BRIEF.md
# ADC Output Formatting Pipeline

This block sits between a modelled 14-bit converter core and the host-facing result register. The core delivers one raw offset-binary code per clock, together with a sample-valid strobe and a per-sample over-range bit. The block can first replace the raw code with a fixed test code, selected by a three-bit test field. It then subtracts a signed 8-bit offset, unless offset correction is bypassed, and clamps the result to the 14-bit code range. Finally it recodes the word as straight binary or as two's complement.

The formatted word and its over-range flag leave through a fixed-latency delay line, so the flag always arrives on the same cycle as the word it describes. A power-down control stops new results from appearing. While power-down is set, the output word keeps the last value that was delivered.

Top module: `adc_fmt_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, `out_vld`, `out_ovr` and `out_word` are all 0 after that edge.
- R2: A sample accepted at rising edge k (`smp_vld`=1, `cfg_pwrdn`=0) appears on `out_vld`/`out_word`/`out_ovr` right after rising edge k+LATENCY-1. With the default LATENCY=10, that is ten edges after the inputs were presented. `out_ovr` belongs to the same sample as `out_word`.
- R3: With `cfg_twos`=0 the output is straight binary: the corrected code unchanged, with 0 for negative full scale, 8192 for zero difference and 16383 for the top code.
- R4: With `cfg_twos`=1, bit 13 of the corrected code is inverted. Corrected 8192 gives 0x0000, corrected 0 gives 0x2000 (-8192), and corrected 16383 gives 0x1FFF (+8191).
- R5: With `cfg_ofs_byp`=0, the two's-complement value of `cfg_ofs` is subtracted from the (possibly test-substituted) code.
- R6: With `cfg_ofs_byp`=1, `cfg_ofs` has no effect on the output.
- R7: A corrected value below 0 is clamped to 0, and one above 16383 is clamped to 16383. In either case `out_ovr` is 1 for that sample.
- R8: In normal mode, `raw_ovr` of a sample is carried to `out_ovr` of that sample, ORed with the clamp indication.
- R9: `cfg_test` values 3'b000 and 3'b100 pass `raw_code`. Values 3'b001 and 3'b101 substitute the mid-scale code 8192 and clear the core over-range bit.
- R10: `cfg_test` 3'b011 substitutes 16383 and 3'b111 substitutes 0, each with the core over-range bit cleared.
- R11: `cfg_test` 3'b010 substitutes 12288 (mid-scale + 4096) and 3'b110 substitutes 4096 (mid-scale - 4096), each with the core over-range bit cleared.
- R12: Samples presented while `cfg_pwrdn`=1 are discarded. `out_vld` is 0 after any rising edge at which `cfg_pwrdn` was 1. `out_word` and `out_ovr` change only after edges where `out_vld` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Raw sample present this cycle |
| raw_code | input | 14 | Raw offset-binary code from the converter core |
| raw_ovr | input | 1 | Core over-range indication for this sample |
| cfg_twos | input | 1 | Output coding: 0 straight binary, 1 two's complement |
| cfg_ofs_byp | input | 1 | 1 bypasses offset correction |
| cfg_ofs | input | 8 | Signed offset subtracted from each code |
| cfg_test | input | 3 | Test code substitution select |
| cfg_pwrdn | input | 1 | Power-down: discard samples, mute valid |
| out_word | output | 14 | Formatted result word |
| out_ovr | output | 1 | Over-range flag aligned with `out_word` |
| out_vld | output | 1 | New result on `out_word` this cycle |

## Verification
The bench uses the default parameters: LATENCY=10, a 14-bit code and an 8-bit offset. The ten-stage delay is therefore checked at exactly the count the requirements name. An offset span of -128..127 can push codes near either end of the range past the clamp, so saturation at both ends is reachable from ordinary samples. Random samples are mixed with directed cases, which cover every test code in both output formats, bypassed nonzero offsets, and power-down bursts that begin and end while samples are still inside the delay line.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    localparam int CODE_W   = 14;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int CODE_MID = 1 << (CODE_W - 1);
    localparam int CODE_QTR = 1 << (CODE_W - 2);

    typedef logic [CODE_W-1:0] code_t;

    // one sample travelling through the datapath
    typedef struct packed {
        logic  vld;
        code_t word;
        logic  ovr;
    } smp_t;

    typedef enum logic [2:0] {
        TM_PASS_A  = 3'b000,
        TM_MID_A   = 3'b001,
        TM_HALF_UP = 3'b010,
        TM_TOP     = 3'b011,
        TM_PASS_B  = 3'b100,
        TM_MID_B   = 3'b101,
        TM_HALF_DN = 3'b110,
        TM_BOTTOM  = 3'b111
    } tmode_e;

    function automatic code_t to_coding(input code_t c, input logic twos);
        code_t r;
        r = c;
        if (twos) r[CODE_W-1] = ~c[CODE_W-1];
        return r;
    endfunction

endpackage

// File: rtl/adc_fmt_testsel.sv
module adc_fmt_testsel
    import adc_fmt_pkg::*;
(
    input  code_t       code_i,
    input  logic        ovr_i,
    input  logic [2:0]  mode_i,
    output code_t       code_o,
    output logic        ovr_o
);
    tmode_e mode;
    assign mode = tmode_e'(mode_i);

    always_comb begin
        ovr_o  = 1'b0;
        unique case (mode)
            TM_MID_A, TM_MID_B: code_o = code_t'(CODE_MID);
            TM_HALF_UP:         code_o = code_t'(CODE_MID + CODE_QTR);
            TM_HALF_DN:         code_o = code_t'(CODE_MID - CODE_QTR);
            TM_TOP:             code_o = code_t'(CODE_MAX);
            TM_BOTTOM:          code_o = '0;
            default: begin
                code_o = code_i;
                ovr_o  = ovr_i;
            end
        endcase
    end
endmodule

// File: rtl/adc_fmt_correct.sv
module adc_fmt_correct
    import adc_fmt_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  code_t             code_i,
    input  logic              byp_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output code_t             code_o,
    output logic              sat_o
);
    localparam int DW = CODE_W + 2;

    logic signed [DW-1:0] code_s;
    logic signed [DW-1:0] ofs_s;
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] top_s;

    assign code_s = $signed({2'b00, code_i});
    assign ofs_s  = $signed({{(DW-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});
    assign top_s  = $signed({2'b00, {CODE_W{1'b1}}});
    assign diff   = byp_i ? code_s : (code_s - ofs_s);

    always_comb begin
        if (diff < 0) begin
            code_o = '0;
            sat_o  = 1'b1;
        end else if (diff > top_s) begin
            code_o = {CODE_W{1'b1}};
            sat_o  = 1'b1;
        end else begin
            code_o = diff[CODE_W-1:0];
            sat_o  = 1'b0;
        end
    end
endmodule

// File: rtl/adc_fmt_encode.sv
module adc_fmt_encode
    import adc_fmt_pkg::*;
(
    input  logic  vld_i,
    input  code_t code_i,
    input  logic  ovr_i,
    input  logic  sat_i,
    input  logic  twos_i,
    output smp_t  smp_o
);
    always_comb begin
        smp_o.vld  = vld_i;
        smp_o.word = to_coding(code_i, twos_i);
        smp_o.ovr  = ovr_i | sat_i;
    end
endmodule

// File: rtl/adc_fmt_delay.sv
module adc_fmt_delay
    import adc_fmt_pkg::*;
#(
    parameter int LATENCY = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic mute_i,
    input  smp_t smp_i,
    output smp_t smp_o
);
    localparam int NSTG = LATENCY - 1;

    smp_t [NSTG-1:0] stg_q;
    smp_t            tail;
    smp_t            out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= smp_i;
            for (int i = 1; i < NSTG; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign tail = stg_q[NSTG-1];

    // final stage keeps its word while nothing new arrives
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld <= tail.vld & ~mute_i;
            if (tail.vld & ~mute_i) begin
                out_q.word <= tail.word;
                out_q.ovr  <= tail.ovr;
            end
        end
    end

    assign smp_o = out_q;
endmodule

// File: rtl/adc_fmt_pipe.sv
module adc_fmt_pipe
    import adc_fmt_pkg::*;
#(
    parameter int LATENCY = 10,
    parameter int OFS_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [13:0]       raw_code,
    input  logic              raw_ovr,
    input  logic              cfg_twos,
    input  logic              cfg_ofs_byp,
    input  logic [OFS_W-1:0]  cfg_ofs,
    input  logic [2:0]        cfg_test,
    input  logic              cfg_pwrdn,
    output logic [13:0]       out_word,
    output logic              out_ovr,
    output logic              out_vld
);
    code_t t_code;
    logic  t_ovr;
    code_t c_code;
    logic  c_sat;
    smp_t  enc;
    smp_t  dly;

    adc_fmt_testsel u_tsel (
        .code_i (raw_code),
        .ovr_i  (raw_ovr),
        .mode_i (cfg_test),
        .code_o (t_code),
        .ovr_o  (t_ovr)
    );

    adc_fmt_correct #(.OFS_W(OFS_W)) u_corr (
        .code_i (t_code),
        .byp_i  (cfg_ofs_byp),
        .ofs_i  (cfg_ofs),
        .code_o (c_code),
        .sat_o  (c_sat)
    );

    adc_fmt_encode u_enc (
        .vld_i  (smp_vld & ~cfg_pwrdn),
        .code_i (c_code),
        .ovr_i  (t_ovr),
        .sat_i  (c_sat),
        .twos_i (cfg_twos),
        .smp_o  (enc)
    );

    adc_fmt_delay #(.LATENCY(LATENCY)) u_dly (
        .clk    (clk),
        .rst    (rst),
        .mute_i (cfg_pwrdn),
        .smp_i  (enc),
        .smp_o  (dly)
    );

    assign out_word = dly.word;
    assign out_ovr  = dly.ovr;
    assign out_vld  = dly.vld;
endmodule

// File: rtl/adc_fmt_chk.sv
module adc_fmt_chk #(
    parameter int LATENCY = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        smp_vld,
    input logic        cfg_pwrdn,
    input logic [13:0] out_word,
    input logic        out_ovr,
    input logic        out_vld
);
    logic [LATENCY-1:0] acc_hist;

    always_ff @(posedge clk) begin
        if (rst) acc_hist <= '0;
        else     acc_hist <= {acc_hist[LATENCY-2:0], smp_vld & ~cfg_pwrdn};
    end

    AST_RST_IDLE: assert property (@(posedge clk)
        rst |=> (!out_vld && !out_ovr && out_word == '0)); // R1

    AST_LAT_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_vld == (acc_hist[LATENCY-1] && !$past(cfg_pwrdn))); // R2

    AST_PWRDN_MUTE: assert property (@(posedge clk) disable iff (rst)
        cfg_pwrdn |=> !out_vld); // R12

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> ($stable(out_word) && $stable(out_ovr))); // R12
endmodule

bind adc_fmt_pipe adc_fmt_chk #(.LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .cfg_pwrdn (cfg_pwrdn),
    .out_word  (out_word),
    .out_ovr   (out_ovr),
    .out_vld   (out_vld)
);

// File: tb/adc_fmt_pipe_tb.sv
module adc_fmt_pipe_tb;
    localparam int LAT = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, smp_vld, raw_ovr, cfg_twos, cfg_ofs_byp, cfg_pwrdn;
    logic [13:0] raw_code;
    logic [7:0]  cfg_ofs;
    logic [2:0]  cfg_test;
    logic [13:0] out_word;
    logic        out_ovr, out_vld;

    adc_fmt_pipe #(.LATENCY(LAT), .OFS_W(8)) u_dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .raw_code(raw_code),
        .raw_ovr(raw_ovr), .cfg_twos(cfg_twos), .cfg_ofs_byp(cfg_ofs_byp),
        .cfg_ofs(cfg_ofs), .cfg_test(cfg_test), .cfg_pwrdn(cfg_pwrdn),
        .out_word(out_word), .out_ovr(out_ovr), .out_vld(out_vld)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic        h_vld [16];
    logic        h_pd  [16];
    logic [13:0] h_word[16];
    logic        h_ovr [16];
    string       h_tag [16];
    logic [13:0] m_word = '0;
    logic        m_ovr  = 1'b0;
    logic        last_pd = 1'b0;

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // independent reference of the whole datapath
    task automatic model(input int code, input logic ov, input logic tw, input logic byp,
                         input int ofs, input int tm,
                         output logic [13:0] w, output logic o, output logic s);
        int c, v;
        logic oo;
        oo = 1'b0;
        case (tm)
            1, 5:    c = 8192;
            3:       c = 16383;
            7:       c = 0;
            2:       c = 12288;
            6:       c = 4096;
            default: begin c = code; oo = ov; end
        endcase
        v = byp ? c : c - ofs;
        s = 1'b0;
        if (v < 0)     begin v = 0;     s = 1'b1; end
        if (v > 16383) begin v = 16383; s = 1'b1; end
        w = v[13:0];
        if (tw) w[13] = ~w[13];
        o = oo | s;
    endtask

    function automatic string tag_of(input int tm, input logic byp, input int ofs,
                                     input logic s, input logic ov, input logic tw);
        if (tm == 1 || tm == 5) return "R9";
        if (tm == 3 || tm == 7) return "R10";
        if (tm == 2 || tm == 6) return "R11";
        if (s)                  return "R7";
        if (ov)                 return "R8";
        if (byp && ofs != 0)    return "R6";
        if (!byp && ofs != 0)   return "R5";
        if (tw)                 return "R4";
        return "R3";
    endfunction

    task automatic step(input logic v, input int code, input logic ov, input logic tw,
                        input logic byp, input int ofs, input int tm, input logic pd);
        int   i;
        logic ev;
        logic [13:0] w;
        logic o, s;
        @(negedge clk);
        i  = (cyc - LAT) & 15;
        ev = (cyc >= LAT) && h_vld[i] && !h_pd[i] && !last_pd;
        if (ev) begin
            m_word = h_word[i];
            m_ovr  = h_ovr[i];
        end
        chk((cyc >= LAT && (h_pd[i] || last_pd)) ? "R12" : "R2", out_vld, ev, "out_vld");
        chk(ev ? h_tag[i] : "R12", out_word, m_word, "out_word");
        chk(ev ? h_tag[i] : "R12", out_ovr, m_ovr, "out_ovr");
        smp_vld     = v;
        raw_code    = code[13:0];
        raw_ovr     = ov;
        cfg_twos    = tw;
        cfg_ofs_byp = byp;
        cfg_ofs     = ofs[7:0];
        cfg_test    = tm[2:0];
        cfg_pwrdn   = pd;
        model(code, ov, tw, byp, ofs, tm, w, o, s);
        i = cyc & 15;
        h_vld[i]  = v;
        h_pd[i]   = pd;
        h_word[i] = w;
        h_ovr[i]  = o;
        h_tag[i]  = tag_of(tm, byp, ofs, s, ov, tw);
        last_pd   = pd;
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 0, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int k = 0; k < 16; k++) h_vld[k] = 1'b0;
        rst = 1'b1; smp_vld = 1'b1; raw_code = 14'h3FFF; raw_ovr = 1'b1;
        cfg_twos = 1'b0; cfg_ofs_byp = 1'b1; cfg_ofs = '0; cfg_test = '0; cfg_pwrdn = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", out_vld, 0, "out_vld");
        chk("R1", out_word, 0, "out_word");
        chk("R1", out_ovr, 0, "out_ovr");
        smp_vld = 1'b0;
        rst = 1'b0;

        // R2: single sample, counted latency
        step(1'b1, 1234, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0);
        idle(LAT + 2);
        // R3 / R4: the three anchor codes in both codings
        for (int f = 0; f < 2; f++) begin
            step(1'b1, 0,     1'b0, f[0], 1'b1, 0, 0, 1'b0);
            step(1'b1, 8192,  1'b0, f[0], 1'b1, 0, 0, 1'b0);
            step(1'b1, 16383, 1'b0, f[0], 1'b1, 0, 0, 1'b0);
        end
        // R5, R6, R7, R8
        step(1'b1, 100,   1'b0, 1'b0, 1'b0, 5,    0, 1'b0);
        step(1'b1, 100,   1'b0, 1'b1, 1'b0, -7,   0, 1'b0);
        step(1'b1, 500,   1'b0, 1'b0, 1'b1, 77,   0, 1'b0);
        step(1'b1, 16300, 1'b0, 1'b0, 1'b0, -128, 0, 1'b0);
        step(1'b1, 50,    1'b0, 1'b1, 1'b0, 127,  0, 1'b0);
        step(1'b1, 9000,  1'b1, 1'b0, 1'b1, 0,    0, 1'b0);
        // R9, R10, R11: every test code in both codings, core over-range raised
        for (int f = 0; f < 2; f++)
            for (int t = 0; t < 8; t++)
                step(1'b1, 3333, 1'b1, f[0], 1'b1, 0, t, 1'b0);
        // R12: power-down burst while samples are in flight
        for (int k = 0; k < 4; k++) step(1'b1, 200 + k, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0);
        for (int k = 0; k < 6; k++) step(1'b1, 7000,    1'b1, 1'b0, 1'b1, 0, 0, 1'b1);
        idle(LAT + 2);

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            int   ob, ofs, tm;
            logic pd;
            ob  = int'($urandom % 256);
            ofs = (ob >= 128) ? ob - 256 : ob;
            tm  = ($urandom % 4 == 0) ? int'($urandom % 8) : 0;
            pd  = ($urandom % 16 == 0);
            step($urandom % 4 != 0, int'($urandom % 16384), $urandom % 8 == 0,
                 $urandom % 2 == 1, $urandom % 3 == 0, ofs, tm, pd);
        end
        idle(LAT + 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule